// File: doc/BRIEF.md
# Per-Channel Output-Enable Bit Serializer

This block produces four constant-rate serial control lines that tell downstream drivers, channel by channel, whether each of 32 time-division-multiplexed output streams should drive or float. Every line shifts one bit per output-clock period (16.384 MHz) and is shared by eight streams that take turns in a fixed rotation. A stream running slower than the line rate keeps its channel for longer, so its enable bit reappears on the line once per rotation until the channel ends.

The enable bits live in an external per-stream, per-channel store. For every line the block issues a read address (stream and channel) each period and expects the bit back one clock later. The period counter is aligned by a frame pulse. The bits are sent early: the line schedule runs a fixed number of periods ahead of the frame boundary so that drivers can act before their slot opens. A priority gate forces every line LOW and withdraws stream drive while reset is held, while the drive-enable input is low, or while the standby control is low.

Top module: `oe_bit_serializer`

## Requirements
- R1: Line k (k = 0..3) carries only streams k, k+4, ..., k+28. Its store read address is rd_addr_o[13k+12:13k], with bits [12:8] the stream number and bits [7:0] the channel number. The store returns the bit on rd_data_i[k] one clock after the address is presented.
- R2: During frame period p, cs_o[k] is the enable bit of stream k+4i, channel c, where o = (p+10) mod 2048, i = o mod 8 and c = (o div 8) >> (3 - rate code of that stream). Channel 0 of stream index 7 therefore leads the frame boundary by 3 periods, and that of index 0 by 10.
- R3: Rate code per stream is rate_i[2s+1:2s]: 00 = 2.048 Mbps (32 channels, bit sent 8 times), 01 = 4.096 (64, 4 times), 10 = 8.192 (128, twice), 11 = 16.384 (256, once).
- R4: When fp_i is high at a clock edge, the next period is period 0. Without a pulse the period count wraps from 2047 to 0 by itself.
- R5: After reset, cs_o stays 0 until the first frame pulse, and it stays 0 for periods 0 and 1 after that pulse.
- R6: While rst_n is low, cs_o is 0 and drive_en_o is 0 at once, and frame alignment is lost until the next frame pulse.
- R7: While ode_i or sby_i is low, cs_o is 0 and drive_en_o is 0 without delay. Once both are high again, the lines resume on the same frame schedule.
- R8: drive_en_o is 1 exactly when rst_n, ode_i and sby_i are all high. In that state a LOW control bit marks its channel as high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output clock, one control bit per period |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fp_i | input | 1 | Frame pulse; next period is period 0 |
| ode_i | input | 1 | Output drive enable, active high |
| sby_i | input | 1 | Output standby control, high = operate |
| rate_i | input | 64 | Two-bit rate code per stream |
| rd_addr_o | output | 52 | Per-line store address {stream, channel} |
| rd_data_i | input | 4 | Per-line enable bit, one clock after address |
| cs_o | output | 4 | Serial control lines |
| drive_en_o | output | 1 | Stream outputs may drive |

## Verification
The properties assume that the enable store answers one clock after each address. They also assume that frame pulses either arrive once at period 2047 or do not arrive at all, so the period count stays continuous once locked. The channel-range and lane properties further assume that rate codes change only between periods. The stimulus changes rate codes only at a falling edge and waits three periods before it relies on a result. It models the store as a synchronous read in the bench, and it issues frame pulses only at the frame end, except for the single pulse that first aligns the block.

// File: rtl/oebs_pkg.sv
package oebs_pkg;

  localparam int unsigned LINE_CNT   = 4;
  localparam int unsigned SLOT_CNT   = 8;
  localparam int unsigned FRAME_LEN  = 2048;
  localparam int unsigned LEAD_PER   = 10;
  localparam int unsigned READ_AHEAD = 2;
  localparam int unsigned MAX_SHIFT  = 3;

  typedef enum logic [1:0] {
    RATE_2M  = 2'b00,
    RATE_4M  = 2'b01,
    RATE_8M  = 2'b10,
    RATE_16M = 2'b11
  } rate_e;

  // Period number whose line slot is being prepared.
  function automatic int unsigned look_ahead(int unsigned per, int unsigned ahead,
                                             int unsigned frame);
    return (per + ahead) % frame;
  endfunction

  // Number of line rotations that share one channel is 2**shift.
  function automatic int unsigned rate_shift(logic [1:0] code);
    return MAX_SHIFT - int'(code);
  endfunction

  function automatic int unsigned chan_index(int unsigned offs, int unsigned slots,
                                             logic [1:0] code);
    return (offs / slots) >> rate_shift(code);
  endfunction

  function automatic int unsigned stream_of(int unsigned line, int unsigned slot,
                                            int unsigned lines);
    return line + lines * slot;
  endfunction

endpackage

// File: rtl/oebs_period_ctr.sv
module oebs_period_ctr #(
  parameter int unsigned FRAME = oebs_pkg::FRAME_LEN,
  parameter int unsigned PER_W = $clog2(FRAME)
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             fp_i,
  output logic [PER_W-1:0] period_o,
  output logic             locked_o
);

  localparam logic [PER_W-1:0] LAST = PER_W'(FRAME - 1);

  logic [PER_W-1:0] cnt_q;
  logic             lock_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (fp_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b1;
    end else if (at_last) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign period_o = cnt_q;
  assign locked_o = lock_q;

endmodule

// File: rtl/oebs_addr_gen.sv
module oebs_addr_gen #(
  parameter int unsigned LINES = oebs_pkg::LINE_CNT,
  parameter int unsigned SLOTS = oebs_pkg::SLOT_CNT,
  parameter int unsigned FRAME = oebs_pkg::FRAME_LEN,
  parameter int unsigned LEAD  = oebs_pkg::LEAD_PER,
  parameter int unsigned AHEAD = oebs_pkg::READ_AHEAD,
  parameter int unsigned PER_W = $clog2(FRAME),
  parameter int unsigned STR_W = $clog2(LINES * SLOTS),
  parameter int unsigned CH_W  = $clog2(FRAME / SLOTS),
  parameter int unsigned AW    = STR_W + CH_W
) (
  input  logic [PER_W-1:0]           period_i,
  input  logic [2*LINES*SLOTS-1:0]   rate_i,
  output logic [LINES*AW-1:0]        rd_addr_o
);
  import oebs_pkg::*;

  logic [PER_W-1:0] offs;
  int unsigned      slot;

  always_comb begin
    offs = PER_W'(look_ahead(int'(period_i), LEAD + AHEAD, FRAME));
    slot = int'(offs) % SLOTS;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    logic [STR_W-1:0] str;
    logic [1:0]       code;
    logic [CH_W-1:0]  ch;

    always_comb begin
      str  = STR_W'(stream_of(g, slot, LINES));
      code = rate_i[2*str +: 2];
      ch   = CH_W'(chan_index(int'(offs), SLOTS, code));
    end

    assign rd_addr_o[g*AW +: AW] = {str, ch};
  end

endmodule

// File: rtl/oebs_line_gate.sv
module oebs_line_gate #(
  parameter int unsigned LINES = oebs_pkg::LINE_CNT
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             locked_i,
  input  logic [LINES-1:0] rd_data_i,
  input  logic             ode_i,
  input  logic             sby_i,
  output logic [LINES-1:0] cs_o,
  output logic             drive_en_o
);

  logic [LINES-1:0] line_q;
  logic             addr_ok_q;
  logic             line_ok_q;

  // Two-stage valid: address from a locked count, then data captured.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      addr_ok_q <= 1'b0;
      line_ok_q <= 1'b0;
    end else begin
      line_q    <= rd_data_i;
      addr_ok_q <= locked_i;
      line_ok_q <= addr_ok_q;
    end
  end

  assign drive_en_o = rst_n & ode_i & sby_i;
  assign cs_o       = (line_ok_q && drive_en_o) ? line_q : '0;

endmodule

// File: rtl/oe_bit_serializer.sv
module oe_bit_serializer #(
  parameter int unsigned LINES = oebs_pkg::LINE_CNT,
  parameter int unsigned SLOTS = oebs_pkg::SLOT_CNT,
  parameter int unsigned FRAME = oebs_pkg::FRAME_LEN,
  parameter int unsigned LEAD  = oebs_pkg::LEAD_PER,
  localparam int unsigned STREAMS = LINES * SLOTS,
  localparam int unsigned PER_W   = $clog2(FRAME),
  localparam int unsigned STR_W   = $clog2(STREAMS),
  localparam int unsigned CH_W    = $clog2(FRAME / SLOTS),
  localparam int unsigned AW      = STR_W + CH_W
) (
  input  logic                 clk_i,
  input  logic                 rst_n,
  input  logic                 fp_i,
  input  logic                 ode_i,
  input  logic                 sby_i,
  input  logic [2*STREAMS-1:0] rate_i,
  output logic [LINES*AW-1:0]  rd_addr_o,
  input  logic [LINES-1:0]     rd_data_i,
  output logic [LINES-1:0]     cs_o,
  output logic                 drive_en_o
);

  logic [PER_W-1:0] period_q;
  logic             frame_lock;

  oebs_period_ctr #(
    .FRAME (FRAME),
    .PER_W (PER_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .fp_i     (fp_i),
    .period_o (period_q),
    .locked_o (frame_lock)
  );

  oebs_addr_gen #(
    .LINES (LINES),
    .SLOTS (SLOTS),
    .FRAME (FRAME),
    .LEAD  (LEAD),
    .AHEAD (oebs_pkg::READ_AHEAD),
    .PER_W (PER_W),
    .STR_W (STR_W),
    .CH_W  (CH_W),
    .AW    (AW)
  ) u_addr (
    .period_i  (period_q),
    .rate_i    (rate_i),
    .rd_addr_o (rd_addr_o)
  );

  oebs_line_gate #(
    .LINES (LINES)
  ) u_gate (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .locked_i   (frame_lock),
    .rd_data_i  (rd_data_i),
    .ode_i      (ode_i),
    .sby_i      (sby_i),
    .cs_o       (cs_o),
    .drive_en_o (drive_en_o)
  );

endmodule

// File: rtl/oebs_checker.sv
module oebs_checker #(
  parameter int unsigned LINES = oebs_pkg::LINE_CNT,
  parameter int unsigned SLOTS = oebs_pkg::SLOT_CNT,
  parameter int unsigned FRAME = oebs_pkg::FRAME_LEN,
  localparam int unsigned STREAMS = LINES * SLOTS,
  localparam int unsigned PER_W   = $clog2(FRAME),
  localparam int unsigned STR_W   = $clog2(STREAMS),
  localparam int unsigned CH_W    = $clog2(FRAME / SLOTS),
  localparam int unsigned AW      = STR_W + CH_W
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic                 fp_i,
  input logic                 ode_i,
  input logic                 sby_i,
  input logic [2*STREAMS-1:0] rate_i,
  input logic [LINES*AW-1:0]  rd_addr_o,
  input logic [LINES-1:0]     cs_o,
  input logic                 drive_en_o,
  input logic [PER_W-1:0]     period,
  input logic                 locked
);

  assert_frame_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    fp_i |=> (period == '0))
    else $error("frame pulse did not restart the period count");

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (locked && !fp_i) |=>
      (period == (($past(period) == PER_W'(FRAME - 1)) ? '0 : $past(period) + 1'b1)))
    else $error("period count did not advance or wrap");

  assert_idle_unlocked_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !locked |-> (cs_o == '0))
    else $error("control line active before frame alignment");

  assert_gate_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ode_i || !sby_i) |-> ((cs_o == '0) && !drive_en_o))
    else $error("gate low but lines or drive active");

  assert_drive_on_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ode_i && sby_i) |-> drive_en_o)
    else $error("drive withheld with all enables high");

  always @(negedge clk_i) begin
    if (!rst_n) begin
      assert_reset_quiet_R6: assert ((cs_o == '0) && !drive_en_o)
        else $error("lines or drive active during reset");
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_lane_chk
    logic [STR_W-1:0] lane_str;
    logic [CH_W-1:0]  lane_ch;
    logic [1:0]       lane_code;

    always_comb begin
      lane_str  = rd_addr_o[l*AW + CH_W +: STR_W];
      lane_ch   = rd_addr_o[l*AW +: CH_W];
      lane_code = rate_i[2*lane_str +: 2];
    end

    assert_lane_stream_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
      locked |-> ((lane_str % STR_W'(LINES)) == STR_W'(l)))
      else $error("lane addresses a stream of another line");

    assert_chan_range_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
      locked |-> ((lane_ch >> (CH_W - oebs_pkg::MAX_SHIFT + lane_code)) == '0))
      else $error("channel beyond the count for the stream rate");
  end

endmodule

bind oe_bit_serializer oebs_checker u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .fp_i       (fp_i),
  .ode_i      (ode_i),
  .sby_i      (sby_i),
  .rate_i     (rate_i),
  .rd_addr_o  (rd_addr_o),
  .cs_o       (cs_o),
  .drive_en_o (drive_en_o),
  .period     (period_q),
  .locked     (frame_lock)
);

// File: tb/oe_bit_serializer_tb.sv
`timescale 1ns/1ps
module oe_bit_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp_force = 1'b0;
  logic        fp_auto_p = 1'b0;
  logic        fp_auto = 1'b0;
  logic        fp;
  logic        ode = 1'b1;
  logic        sby = 1'b1;
  logic [63:0] rate_v;
  logic [51:0] rd_addr;
  logic [3:0]  rd_data = '0;
  logic [3:0]  cs;
  logic        drv;

  int rate_cfg [32];
  int bper = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign fp = fp_force | fp_auto_p;

  always_comb begin
    for (int s = 0; s < 32; s++) rate_v[2*s +: 2] = 2'(rate_cfg[s]);
  end

  oe_bit_serializer dut_i (
    .clk_i      (clk),
    .rst_n      (rst_n),
    .fp_i       (fp),
    .ode_i      (ode),
    .sby_i      (sby),
    .rate_i     (rate_v),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .cs_o       (cs),
    .drive_en_o (drv)
  );

  // Enable-bit pattern held by the modelled store.
  function automatic bit enf(int s, int c);
    return ((s * 5 + c * 3 + c / 4) % 7) > 3;
  endfunction

  // R2/R3 schedule restated from the requirement text.
  function automatic bit exp_bit(int p, int k);
    int o, i, s, c;
    o = (p + 10) % 2048;
    i = o % 8;
    s = k + 4 * i;
    c = (o / 8) >> (3 - rate_cfg[s]);
    return enf(s, c);
  endfunction

  // Synchronous-read store, one clock latency (R1).
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      rd_data[k] <= enf(int'(rd_addr[k*13 + 8 +: 5]), int'(rd_addr[k*13 +: 8]));
  end

  always @(posedge clk) bper <= fp ? 0 : ((bper == 2047) ? 0 : bper + 1);
  always @(negedge clk) fp_auto_p <= fp_auto && (bper == 2047);

  task automatic check(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s period=%0d got=%0d expected=%0d", tag, bper, got, exp);
    end
  endtask

  task automatic check_lines_model(string tag);
    for (int k = 0; k < 4; k++) check(int'(cs[k]), int'(exp_bit(bper, k)), tag);
  endtask

  task automatic set_uniform(int r);
    for (int s = 0; s < 32; s++) rate_cfg[s] = r;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // rate, period, line, stream, channel
  localparam int VEC [8][5] = '{
    '{3,    0, 0,  8,   1},
    '{0,    0, 0,  8,   0},
    '{0, 2045, 3, 31,   0},
    '{3, 2045, 1, 29,   0},
    '{2,  100, 2, 26,   6},
    '{1, 2037, 0, 28,  63},
    '{3, 2037, 3, 31, 255},
    '{1,  500, 1, 25,  15}
  };

  initial begin
    set_uniform(3);
    repeat (4) @(negedge clk);
    check(int'(cs), 0, "R6 reset lines");
    check(int'(drv), 0, "R6 reset drive");
    rst_n = 1'b1;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      check(int'(cs), 0, "R5 before frame pulse");
    end
    check(int'(drv), 1, "R8 drive enabled");

    fp_force = 1'b1;
    @(negedge clk);
    fp_force = 1'b0;
    check(bper, 0, "R4 bench period aligned");
    check(int'(cs), 0, "R5 period 0 after first pulse");
    @(negedge clk);
    check(int'(cs), 0, "R5 period 1 after first pulse");
    fp_auto = 1'b1;

    // Table walk: single-bit probes at hand-derived schedule points.
    for (int v = 0; v < 8; v++) begin
      set_uniform(VEC[v][0]);
      repeat (3) @(negedge clk);
      while (bper != VEC[v][1]) @(negedge clk);
      check(int'(cs[VEC[v][2]]), int'(enf(VEC[v][3], VEC[v][4])), "R2 R3 probe");
    end

    // Mixed rates, full frame without pulses: schedule, repetition and wrap.
    for (int s = 0; s < 32; s++) rate_cfg[s] = (s * 3 + 1) % 4;
    fp_auto = 1'b0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 2100; n++) begin
      @(negedge clk);
      check_lines_model("R2 R3 R4 sweep");
    end
    fp_auto = 1'b1;

    // Drive-enable low, then restore on the same schedule.
    @(negedge clk);
    ode = 1'b0;
    for (int n = 0; n < 16; n++) begin
      #1;
      check(int'(cs), 0, "R7 ode low lines");
      check(int'(drv), 0, "R7 ode low drive");
      @(negedge clk);
    end
    ode = 1'b1;
    for (int n = 0; n < 16; n++) begin
      #1;
      check_lines_model("R7 resume after ode");
      @(negedge clk);
    end

    sby = 1'b0;
    for (int n = 0; n < 16; n++) begin
      #1;
      check(int'(cs), 0, "R7 standby lines");
      check(int'(drv), 0, "R7 standby drive");
      @(negedge clk);
    end
    sby = 1'b1;
    #1;
    check(int'(drv), 1, "R8 drive back");
    check_lines_model("R7 resume after standby");

    // Reset in mid-frame: immediate quiet, then wait for realignment.
    @(negedge clk);
    fp_auto = 1'b0;
    rst_n = 1'b0;
    #1;
    check(int'(cs), 0, "R6 mid reset lines");
    check(int'(drv), 0, "R6 mid reset drive");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      check(int'(cs), 0, "R6 no lines until realigned");
    end
    fp_auto = 1'b1;
    while (bper != 2047) @(negedge clk);
    while (bper != 5) @(negedge clk);
    for (int n = 0; n < 24; n++) begin
      check_lines_model("R4 R2 after realign");
      @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule